// File: doc/BRIEF.md
# Seconds Counter Register Interface

This block keeps a 32-bit count of elapsed seconds and presents it to a bus master through a small synchronous register port. A one-cycle tick input, pulsed once per second by a prescaler elsewhere, advances the count. Software reads the count as two 16-bit halves, each at its own offset, and zero-extends it into the read data word.

Overwriting the count is protected by a write-enable latch. Software first sets the latch through a control offset. It then writes the low half, which leaves the latch set, and then the high half, which clears the latch. A complete update is therefore the sequence unlock, low write, high write. Stray writes made while the latch is clear leave the count unchanged.

Top module: `rtc_regif`

## Requirements
- R1: Only `addr_i[7:0]` is decoded. Any higher address bits do not change which register is selected.
- R2: A read strobe at offset 0x00 loads `rdata_o`, at the next clock edge, with the upper 16 bits of the count in `rdata_o[15:0]` and zeros above them.
- R3: A read strobe at offset 0x04 loads `rdata_o`, at the next clock edge, with the lower 16 bits of the count, zero-extended.
- R4: A read strobe at offset 0x08, or at any offset other than 0x00 and 0x04, loads zero into `rdata_o`.
- R5: A write to offset 0x08 sets the write-enable latch to `wdata_i[0]`.
- R6: A write to offset 0x00 while the latch is set replaces count bits 31:16 with `wdata_i[15:0]` and clears the latch.
- R7: A write to offset 0x04 while the latch is set replaces count bits 15:0 with `wdata_i[15:0]` and leaves the latch set.
- R8: Writes to offsets 0x00 or 0x04 while the latch is clear have no effect. Writes to offsets other than 0x00, 0x04 and 0x08 have no effect on the count or on the latch.
- R9: Each cycle with `tick_i` high adds one to the count, and 0xFFFFFFFF wraps to 0.
- R10: When an accepted half write and a tick fall in the same cycle, the written half takes the write data and the other half takes its value from the incremented count.
- R11: After reset the count is zero, the latch is clear and `rdata_o` is zero.
- R12: A read returns the count as it was before any write or tick in the same cycle. `rdata_o` holds its value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (16) | Register address; the low 8 bits are decoded |
| wdata_i | input | DATA_W (32) | Write data |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| tick_i | input | 1 | One-second increment pulse |
| rdata_o | output | DATA_W (32) | Registered read data |

## Verification
The assertions assume that the strobes and the tick are single-cycle and synchronous to `clk_i`. They also assume that no input is ever unknown after reset. The bench drives every input on the falling edge, so each strobe or tick is high for exactly one rising edge. It also holds the strobes and the tick low throughout reset. The bench sweeps all 256 decoded offsets, both for reads and for guarded writes, with non-zero upper address bits. It also covers the carry between the halves, the wrap of the count, and writes that coincide with a tick.

// File: rtl/rtc_regif_pkg.sv
package rtc_regif_pkg;
  localparam int unsigned DEC_W = 8;

  localparam logic [DEC_W-1:0] OFF_HI   = 8'h00;
  localparam logic [DEC_W-1:0] OFF_LO   = 8'h04;
  localparam logic [DEC_W-1:0] OFF_CTRL = 8'h08;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_HI,
    SEL_LO,
    SEL_CTRL
  } rtc_sel_e;
endpackage

// File: rtl/rtc_addr_dec.sv
module rtc_addr_dec
  import rtc_regif_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output rtc_sel_e          sel_o
);
  logic [DEC_W-1:0] off;
  assign off = addr_i[DEC_W-1:0];

  always_comb begin
    unique case (off)
      OFF_HI:   sel_o = SEL_HI;
      OFF_LO:   sel_o = SEL_LO;
      OFF_CTRL: sel_o = SEL_CTRL;
      default:  sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/rtc_wr_guard.sv
module rtc_wr_guard
  import rtc_regif_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_en_i,
  input  rtc_sel_e sel_i,
  input  logic     ctrl_bit_i,
  output logic     unlock_o
);
  logic unlock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      unlock_q <= 1'b0;
    else if (wr_en_i && sel_i == SEL_CTRL)
      unlock_q <= ctrl_bit_i;
    else if (wr_en_i && sel_i == SEL_HI && unlock_q)
      unlock_q <= 1'b0; // high half completes the update
  end

  assign unlock_o = unlock_q;

  // R5: control write loads the latch
  a_r5_ctrl_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && sel_i == SEL_CTRL |=> unlock_o == $past(ctrl_bit_i));

  // R8: writes to undecoded offsets leave the latch alone
  a_r8_latch_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && sel_i == SEL_NONE |=> $stable(unlock_o));
endmodule

// File: rtl/rtc_sec_cnt.sv
module rtc_sec_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [CNT_W/2-1:0] ld_data_i,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q, inc, cnt_d;

  assign inc = cnt_q + CNT_W'(tick_i);

  always_comb begin
    cnt_d = inc;
    if (ld_hi_i) cnt_d[CNT_W-1:HALF_W] = ld_data_i;
    if (ld_lo_i) cnt_d[HALF_W-1:0]     = ld_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R9: unobstructed tick advances by one, modulo 2^CNT_W
  a_r9_tick_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !ld_hi_i && !ld_lo_i |=> cnt_o == $past(cnt_o) + CNT_W'(1));

  // R10: loaded low half wins, high half follows the increment
  a_r10_lo_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_lo_i && !ld_hi_i |=> cnt_o[HALF_W-1:0] == $past(ld_data_i) &&
      cnt_o[CNT_W-1:HALF_W] == $past(cnt_o[CNT_W-1:HALF_W] + HALF_W'(tick_i && cnt_o[HALF_W-1:0] == '1)));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !ld_hi_i && !ld_lo_i |=> $stable(cnt_o));
endmodule

// File: rtl/rtc_regif.sv
module rtc_regif
  import rtc_regif_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned HALF_W = CNT_W / 2;

  rtc_sel_e         sel;
  logic             unlock;
  logic             ld_hi, ld_lo;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  rtc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  rtc_wr_guard u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .sel_i      (sel),
    .ctrl_bit_i (wdata_i[0]),
    .unlock_o   (unlock)
  );

  assign ld_hi = wr_en_i && unlock && sel == SEL_HI;
  assign ld_lo = wr_en_i && unlock && sel == SEL_LO;

  rtc_sec_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .ld_hi_i   (ld_hi),
    .ld_lo_i   (ld_lo),
    .ld_data_i (wdata_i[HALF_W-1:0]),
    .cnt_o     (cnt)
  );

  always_comb begin
    unique case (sel)
      SEL_HI:  rd_mux = DATA_W'(cnt[CNT_W-1:HALF_W]);
      SEL_LO:  rd_mux = DATA_W'(cnt[HALF_W-1:0]);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  // R8: locked half writes do not disturb the count
  a_r8_locked_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !unlock && !tick_i && (sel == SEL_HI || sel == SEL_LO) |=> $stable(cnt));

  // R6: high write closes the latch
  a_r6_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && unlock && sel == SEL_HI |=> !unlock);

  // R4: control and undecoded offsets read as zero
  a_r4_zero_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && sel != SEL_HI && sel != SEL_LO |=> rdata_o == '0);

  // R12: read data holds without a strobe
  a_r12_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/rtc_regif_tb.sv
`timescale 1ns/1ps
module rtc_regif_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [31:0] rdata;

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_cnt;

  always #2 clk = ~clk;

  rtc_regif dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .tick_i(tick), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d, input logic t = 1'b0);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; tick = t;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] v, input logic t = 1'b0);
    @(negedge clk);
    addr = a; rd_en = 1'b1; tick = t;
    @(negedge clk);
    rd_en = 1'b0; tick = 1'b0;
    v = rdata;
  endtask

  task automatic rd_cnt(output logic [31:0] v);
    logic [31:0] h, l;
    bus_rd(16'h0000, h);
    bus_rd(16'h0004, l);
    v = {h[15:0], l[15:0]};
    chk("R2", h & 32'hFFFF_0000, 32'h0);
    chk("R3", l & 32'hFFFF_0000, 32'h0);
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk("R11 rdata", rdata, 32'h0);
    rst_n = 1'b1;
    rd_cnt(v); chk("R11 count", v, 32'h0);
    bus_wr(16'h0004, 32'h55); rd_cnt(v); chk("R11 latch clear", v, 32'h0);

    // unlock, low, low, high
    bus_wr(16'h0008, 32'h1);
    bus_wr(16'h0004, 32'hFFFF_1234); rd_cnt(v); chk("R7", v, 32'h0000_1234);
    bus_wr(16'h0004, 32'h5678);      rd_cnt(v); chk("R7 latch kept", v, 32'h0000_5678);
    bus_wr(16'h0000, 32'hDEAD_ABCD); rd_cnt(v); chk("R6", v, 32'hABCD_5678);
    bus_wr(16'h0004, 32'h1111);      rd_cnt(v); chk("R6 relocked", v, 32'hABCD_5678);
    bus_wr(16'h0000, 32'h2222);      rd_cnt(v); chk("R8 locked hi", v, 32'hABCD_5678);

    // R5: latch follows bit 0
    bus_wr(16'h0008, 32'h1); bus_wr(16'h0008, 32'hFFFF_FFFE);
    bus_wr(16'h0004, 32'h9999); rd_cnt(v); chk("R5 cleared", v, 32'hABCD_5678);
    bus_wr(16'h0008, 32'h3);
    bus_wr(16'h0004, 32'h0007); rd_cnt(v); chk("R5 set", v, 32'hABCD_0007);

    // R1: aliasing through upper address bits
    bus_wr(16'h3508, 32'h1);
    bus_wr(16'h7704, 32'hFFFF);
    bus_wr(16'hC300, 32'h0001);
    bus_rd(16'h9100, v); chk("R1 hi", v, 32'h0001);
    bus_rd(16'h9104, v); chk("R1 lo", v, 32'hFFFF);

    // R9: carry, run, wrap
    exp_cnt = 32'h0001_FFFF;
    do_ticks(1); exp_cnt++; rd_cnt(v); chk("R9 carry", v, exp_cnt);
    do_ticks(37); exp_cnt += 37; rd_cnt(v); chk("R9 run", v, exp_cnt);
    bus_wr(16'h0008, 1); bus_wr(16'h0004, 32'hFFFF); bus_wr(16'h0000, 32'hFFFF);
    do_ticks(1); rd_cnt(v); chk("R9 wrap", v, 32'h0);

    // R2/R3/R4: read sweep over all decoded offsets
    bus_wr(16'h0008, 1); bus_wr(16'h0004, 32'hBEEF); bus_wr(16'h0000, 32'hCAFE);
    for (int a = 0; a < 256; a++) begin
      logic [31:0] e;
      e = (a == 0) ? 32'hCAFE : (a == 4) ? 32'hBEEF : 32'h0;
      bus_rd({8'hA5, 8'(a)}, v);
      chk((a == 0) ? "R2" : (a == 4) ? "R3" : "R4", v, e);
    end

    // R8: writes to other offsets, latch held open
    bus_wr(16'h0008, 1);
    for (int a = 0; a < 256; a++) begin
      if (a != 0 && a != 4 && a != 8) bus_wr({8'h5A, 8'(a)}, 32'hFFFF_FFFF);
    end
    rd_cnt(v); chk("R8 other offsets", v, 32'hCAFE_BEEF);
    bus_wr(16'h0004, 32'h0042); rd_cnt(v); chk("R8 latch untouched", v, 32'hCAFE_0042);

    // R10: write coinciding with tick
    bus_wr(16'h0004, 32'hFFFF);
    bus_wr(16'h0004, 32'h1000, 1'b1); rd_cnt(v); chk("R10 lo", v, 32'hCAFF_1000);
    bus_wr(16'h0000, 32'h0100, 1'b1); rd_cnt(v); chk("R10 hi", v, 32'h0100_1001);

    // R12: read sees pre-tick value, then holds
    bus_rd(16'h0004, v, 1'b1); chk("R12 pre-tick", v, 32'h1001);
    do_ticks(3);
    chk("R12 hold", rdata, 32'h1001);
    rd_cnt(v); chk("R12 count", v, 32'h0100_1005);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule